// File: doc/BRIEF.md
# Interrupt Source Trigger-State Router

This block keeps the delivery state of every interrupt source in a single source number space and decides, event by event, whether anything goes out to the CPUs. Each source holds a two-bit state made of a pending flag P (high bit) and a queued flag Q (low bit). It also holds a type flag that marks it as message-signalled or level-sensitive, and a routing entry. The routing entry carries a mask bit, a target CPU number, a priority and an event data word. Trigger strobes and end-of-interrupt strobes, each tagged with a source number, move the state machine. A forwarded event leaves through a single registered output slot with a valid/ready handshake.

The port is sized for an 8192-entry source number space (13-bit source numbers). The number of sources that have storage behind them is a parameter. A register-style write port lets software load the state, the type or the routing entry of any source, and a combinational read-back port shows the stored contents of one source. The routing-level mask works apart from the state machine. A masked source still walks through its states, but nothing is forwarded for it.

Top module: `isr_router`

## Requirements
- R1: After reset every source has state 01 (off), its mask bit set and its type message-signalled (0), and `out_valid` is low.
- R2: An accepted trigger to a source in state 00 moves it to 10. If the source is unmasked, the next cycle shows `out_valid` high with that source's number, CPU, priority and data.
- R3: An accepted trigger to a source in state 10 or 11 moves it to 11 and forwards nothing.
- R4: An accepted trigger to a source in state 01 leaves the state at 01 and forwards nothing.
- R5: An accepted end-of-interrupt in state 10 returns the source to 00 without forwarding. In state 00 it changes nothing.
- R6: An accepted end-of-interrupt in state 11 moves the source to 10 and forwards the event again if the source is unmasked.
- R7: An accepted end-of-interrupt in state 01 leaves the state at 01 and forwards nothing.
- R8: With the mask bit set, triggers and end-of-interrupts make the same state changes as for an unmasked source, but `out_valid` never rises.
- R9: A configuration write takes one cycle. Field code 0 writes the state from `cfg_wdata[1:0]`. Code 1 writes the type from `cfg_wdata[0]` (1 = level-sensitive). Code 2 writes the routing entry laid out as {mask, cpu, prio, data} with data in the low bits. Code 3 writes nothing. A write blocks both strobes in that cycle (`trig_ready` and `eoi_ready` low), and an end-of-interrupt blocks a trigger (`trig_ready` low while `eoi_valid` is high).
- R10: Source numbers at or above the number of stored sources are ignored by triggers, end-of-interrupts and configuration writes. Read-back of such a number reports state 01 with the mask set.
- R11: While `out_valid` is high and `out_ready` is low, the output payload stays unchanged and both `trig_ready` and `eoi_ready` are low.
- R12: `out_lsi` carries the type flag of the forwarded source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger strobe |
| trig_src | input | SPACE_W | Source number of the trigger |
| trig_ready | output | 1 | Trigger accepted this cycle |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_src | input | SPACE_W | Source number of the end-of-interrupt |
| eoi_ready | output | 1 | End-of-interrupt accepted this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 2 | Field code: 0 state, 1 type, 2 routing, 3 none |
| cfg_src | input | SPACE_W | Source number written |
| cfg_wdata | input | 1+CPU_W+PRIO_W+DATA_W | Write data |
| rd_src | input | SPACE_W | Source number shown on the read-back outputs |
| rd_pq | output | 2 | Stored state of `rd_src` |
| rd_lsi | output | 1 | Stored type of `rd_src` |
| rd_route | output | 1+CPU_W+PRIO_W+DATA_W | Stored routing entry of `rd_src` |
| out_valid | output | 1 | Forwarded event present |
| out_ready | input | 1 | Consumer takes the event |
| out_src | output | SPACE_W | Source number of the event |
| out_cpu | output | CPU_W | Target CPU |
| out_prio | output | PRIO_W | Priority of the serving queue |
| out_data | output | DATA_W | Event data word |
| out_lsi | output | 1 | Type of the source |

## Verification
A sweep over every stored source of a 16-source build applies each of the four states, both mask values and both strobe kinds. The resulting state, forwarding decision and payload are compared with an arithmetic model. This separates the trigger and end-of-interrupt transitions from one another, the mask from the state machine, and one source's routing from another's. Source numbers just past the stored range and at the top of the space are sent to show that they neither alias onto low entries nor corrupt them. Held output, simultaneous strobes and a write during strobes show that stalls keep the payload and that the acceptance order is configuration, then end-of-interrupt, then trigger.

// File: rtl/isr_pkg.sv
package isr_pkg;

  // P is the high bit, Q the low bit
  typedef enum logic [1:0] {
    PQ_READY = 2'b00,
    PQ_OFF   = 2'b01,
    PQ_PEND  = 2'b10,
    PQ_HELD  = 2'b11
  } pq_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_TRIG = 2'd1,
    OP_EOI  = 2'd2
  } op_e;

  localparam logic [1:0] FLD_PQ    = 2'd0;
  localparam logic [1:0] FLD_TYPE  = 2'd1;
  localparam logic [1:0] FLD_ROUTE = 2'd2;

  function automatic pq_e pq_after_trigger(input pq_e cur);
    case (cur)
      PQ_READY: return PQ_PEND;
      PQ_PEND:  return PQ_HELD;
      PQ_HELD:  return PQ_HELD;
      default:  return PQ_OFF;
    endcase
  endfunction

  function automatic logic trigger_forwards(input pq_e cur);
    return cur == PQ_READY;
  endfunction

  function automatic pq_e pq_after_eoi(input pq_e cur);
    case (cur)
      PQ_PEND: return PQ_READY;
      PQ_HELD: return PQ_PEND;
      default: return cur;
    endcase
  endfunction

  function automatic logic eoi_forwards(input pq_e cur);
    return cur == PQ_HELD;
  endfunction

endpackage

// File: rtl/isr_state_table.sv
module isr_state_table
  import isr_pkg::*;
#(
  parameter int NUM_SRC = 2048,
  parameter int RT_W    = 48,
  parameter int IDX_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_pq_en,
  input  pq_e              wr_pq,
  input  logic             wr_lsi_en,
  input  logic             wr_lsi,
  input  logic             wr_rt_en,
  input  logic [RT_W-1:0]  wr_rt,
  input  logic [IDX_W-1:0] a_idx,
  output pq_e              a_pq,
  output logic             a_lsi,
  output logic [RT_W-1:0]  a_rt,
  input  logic [IDX_W-1:0] b_idx,
  output pq_e              b_pq,
  output logic             b_lsi,
  output logic [RT_W-1:0]  b_rt
);

  localparam logic [RT_W-1:0] RT_RESET = {1'b1, {(RT_W-1){1'b0}}};

  pq_e             pq_q  [NUM_SRC];
  logic            lsi_q [NUM_SRC];
  logic [RT_W-1:0] rt_q  [NUM_SRC];

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(gi));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pq_q[gi]  <= PQ_OFF;
        lsi_q[gi] <= 1'b0;
        rt_q[gi]  <= RT_RESET;
      end else if (hit) begin
        if (wr_pq_en)  pq_q[gi]  <= wr_pq;
        if (wr_lsi_en) lsi_q[gi] <= wr_lsi;
        if (wr_rt_en)  rt_q[gi]  <= wr_rt;
      end
    end
  end

  assign a_pq  = pq_q[a_idx];
  assign a_lsi = lsi_q[a_idx];
  assign a_rt  = rt_q[a_idx];
  assign b_pq  = pq_q[b_idx];
  assign b_lsi = lsi_q[b_idx];
  assign b_rt  = rt_q[b_idx];

endmodule

// File: rtl/isr_pq_engine.sv
module isr_pq_engine
  import isr_pkg::*;
(
  input  op_e  op,
  input  logic in_range,
  input  pq_e  cur_pq,
  input  logic masked,
  output pq_e  nxt_pq,
  output logic pq_we,
  output logic fire
);

  logic raw_fire;

  always_comb begin
    case (op)
      OP_TRIG: begin
        nxt_pq   = pq_after_trigger(cur_pq);
        raw_fire = trigger_forwards(cur_pq);
      end
      OP_EOI: begin
        nxt_pq   = pq_after_eoi(cur_pq);
        raw_fire = eoi_forwards(cur_pq);
      end
      default: begin
        nxt_pq   = cur_pq;
        raw_fire = 1'b0;
      end
    endcase
  end

  assign pq_we = in_range && (op != OP_NONE);
  assign fire  = in_range && raw_fire && !masked;

endmodule

// File: rtl/isr_out_stage.sv
module isr_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         slot_free
);

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/isr_router.sv
module isr_router
  import isr_pkg::*;
#(
  parameter int SPACE_W = 13,
  parameter int NUM_SRC = 2048,
  parameter int CPU_W   = 12,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              trig_valid,
  input  logic [SPACE_W-1:0]                trig_src,
  output logic                              trig_ready,
  input  logic                              eoi_valid,
  input  logic [SPACE_W-1:0]                eoi_src,
  output logic                              eoi_ready,
  input  logic                              cfg_we,
  input  logic [1:0]                        cfg_field,
  input  logic [SPACE_W-1:0]                cfg_src,
  input  logic [CPU_W+PRIO_W+DATA_W:0]      cfg_wdata,
  input  logic [SPACE_W-1:0]                rd_src,
  output logic [1:0]                        rd_pq,
  output logic                              rd_lsi,
  output logic [CPU_W+PRIO_W+DATA_W:0]      rd_route,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [SPACE_W-1:0]                out_src,
  output logic [CPU_W-1:0]                  out_cpu,
  output logic [PRIO_W-1:0]                 out_prio,
  output logic [DATA_W-1:0]                 out_data,
  output logic                              out_lsi
);

  localparam int RT_W     = 1 + CPU_W + PRIO_W + DATA_W;
  localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int PRIO_LSB = DATA_W;
  localparam int CPU_LSB  = DATA_W + PRIO_W;
  localparam int MASK_BIT = RT_W - 1;
  localparam int PAY_W    = SPACE_W + 1 + CPU_W + PRIO_W + DATA_W;
  localparam logic [RT_W-1:0] RT_RESET = {1'b1, {(RT_W-1){1'b0}}};

  function automatic logic src_stored(input logic [SPACE_W-1:0] s);
    return int'(s) < NUM_SRC;
  endfunction

  function automatic logic [IDX_W-1:0] src_index(input logic [SPACE_W-1:0] s);
    return s[IDX_W-1:0];
  endfunction

  // named internal events, observed by the checker
  logic             slot_free;
  logic             trig_go;
  logic             eoi_go;
  op_e              op_kind;
  logic [SPACE_W-1:0] op_src;
  logic             op_in_range;
  pq_e              cur_pq;
  logic             cur_lsi;
  logic [RT_W-1:0]  cur_rt;
  logic             cur_mask;
  pq_e              nxt_pq;
  logic             pq_we;
  logic             ev_fire;
  logic             cfg_in_range;

  // acceptance order: configuration, then end-of-interrupt, then trigger
  assign eoi_ready  = !cfg_we && slot_free;
  assign trig_ready = !cfg_we && !eoi_valid && slot_free;
  assign eoi_go     = eoi_valid && eoi_ready;
  assign trig_go    = trig_valid && trig_ready;

  always_comb begin
    if (eoi_go) begin
      op_kind = OP_EOI;
      op_src  = eoi_src;
    end else if (trig_go) begin
      op_kind = OP_TRIG;
      op_src  = trig_src;
    end else begin
      op_kind = OP_NONE;
      op_src  = trig_src;
    end
  end

  assign op_in_range  = src_stored(op_src);
  assign cfg_in_range = src_stored(cfg_src);
  assign cur_mask     = cur_rt[MASK_BIT];

  // table write port shared by configuration and the state machine
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_pq_en;
  pq_e              wr_pq;
  logic             wr_lsi_en;
  logic             wr_rt_en;

  always_comb begin
    if (cfg_we) begin
      wr_en     = cfg_in_range;
      wr_idx    = src_index(cfg_src);
      wr_pq_en  = (cfg_field == FLD_PQ);
      wr_pq     = pq_e'(cfg_wdata[1:0]);
      wr_lsi_en = (cfg_field == FLD_TYPE);
      wr_rt_en  = (cfg_field == FLD_ROUTE);
    end else begin
      wr_en     = pq_we;
      wr_idx    = src_index(op_src);
      wr_pq_en  = 1'b1;
      wr_pq     = nxt_pq;
      wr_lsi_en = 1'b0;
      wr_rt_en  = 1'b0;
    end
  end

  pq_e             rb_pq;
  logic            rb_lsi;
  logic [RT_W-1:0] rb_rt;

  isr_state_table #(
    .NUM_SRC (NUM_SRC),
    .RT_W    (RT_W),
    .IDX_W   (IDX_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_pq_en  (wr_pq_en),
    .wr_pq     (wr_pq),
    .wr_lsi_en (wr_lsi_en),
    .wr_lsi    (cfg_wdata[0]),
    .wr_rt_en  (wr_rt_en),
    .wr_rt     (cfg_wdata),
    .a_idx     (src_index(op_src)),
    .a_pq      (cur_pq),
    .a_lsi     (cur_lsi),
    .a_rt      (cur_rt),
    .b_idx     (src_index(rd_src)),
    .b_pq      (rb_pq),
    .b_lsi     (rb_lsi),
    .b_rt      (rb_rt)
  );

  isr_pq_engine u_engine (
    .op       (op_kind),
    .in_range (op_in_range),
    .cur_pq   (cur_pq),
    .masked   (cur_mask),
    .nxt_pq   (nxt_pq),
    .pq_we    (pq_we),
    .fire     (ev_fire)
  );

  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  assign pay_in = {op_src, cur_lsi, cur_rt[CPU_LSB +: CPU_W],
                   cur_rt[PRIO_LSB +: PRIO_W], cur_rt[0 +: DATA_W]};

  isr_out_stage #(
    .W (PAY_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_fire),
    .load_data (pay_in),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (pay_out),
    .slot_free (slot_free)
  );

  assign {out_src, out_lsi, out_cpu, out_prio, out_data} = pay_out;

  // read-back; unstored numbers look like a freshly reset source
  logic rd_in_range;
  assign rd_in_range = src_stored(rd_src);
  assign rd_pq    = rd_in_range ? rb_pq  : PQ_OFF;
  assign rd_lsi   = rd_in_range ? rb_lsi : 1'b0;
  assign rd_route = rd_in_range ? rb_rt  : RT_RESET;

endmodule

// File: rtl/isr_router_chk.sv
module isr_router_chk
  import isr_pkg::*;
#(
  parameter int SPACE_W = 13,
  parameter int CPU_W   = 12,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               out_valid,
  input logic               out_ready,
  input logic [SPACE_W-1:0] out_src,
  input logic [CPU_W-1:0]   out_cpu,
  input logic [PRIO_W-1:0]  out_prio,
  input logic [DATA_W-1:0]  out_data,
  input logic               out_lsi,
  input logic               trig_ready,
  input logic               eoi_ready,
  input logic               eoi_valid,
  input logic               cfg_we,
  input op_e                op_kind,
  input logic               op_in_range,
  input pq_e                cur_pq,
  input pq_e                nxt_pq,
  input logic               cur_mask,
  input logic               ev_fire
);

  assert_hold_payload_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_src, out_cpu, out_prio, out_data, out_lsi}));

  assert_stall_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !trig_ready && !eoi_ready);

  assert_cfg_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !trig_ready && !eoi_ready);

  assert_eoi_before_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> !trig_ready);

  assert_fire_reaches_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |=> out_valid);

  assert_trig_ready_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_kind == OP_TRIG && op_in_range && cur_pq == PQ_READY |-> nxt_pq == PQ_PEND);

  assert_trig_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_kind == OP_TRIG && cur_pq[1] |-> nxt_pq == PQ_HELD && !ev_fire);

  assert_trig_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_kind == OP_TRIG && cur_pq == PQ_OFF |-> nxt_pq == PQ_OFF && !ev_fire);

  assert_eoi_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_kind == OP_EOI && cur_pq == PQ_PEND |-> nxt_pq == PQ_READY && !ev_fire);

  assert_eoi_replay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_kind == OP_EOI && cur_pq == PQ_HELD |-> nxt_pq == PQ_PEND);

  assert_eoi_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_kind == OP_EOI && cur_pq == PQ_OFF |-> nxt_pq == PQ_OFF && !ev_fire);

  assert_mask_silences_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mask && op_kind != OP_NONE |-> !ev_fire);

  assert_range_silences_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_in_range |-> !ev_fire);

endmodule

bind isr_router isr_router_chk #(
  .SPACE_W (SPACE_W),
  .CPU_W   (CPU_W),
  .PRIO_W  (PRIO_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_src     (out_src),
  .out_cpu     (out_cpu),
  .out_prio    (out_prio),
  .out_data    (out_data),
  .out_lsi     (out_lsi),
  .trig_ready  (trig_ready),
  .eoi_ready   (eoi_ready),
  .eoi_valid   (eoi_valid),
  .cfg_we      (cfg_we),
  .op_kind     (op_kind),
  .op_in_range (op_in_range),
  .cur_pq      (cur_pq),
  .nxt_pq      (nxt_pq),
  .cur_mask    (cur_mask),
  .ev_fire     (ev_fire)
);

// File: tb/isr_router_test.sv
`timescale 1ns/1ps
module isr_router_test;

  localparam int SW = 13;
  localparam int NS = 16;
  localparam int CW = 4;
  localparam int PW = 3;
  localparam int DW = 8;
  localparam int RW = 1 + CW + PW + DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_valid = 1'b0;
  logic [SW-1:0] trig_src = '0;
  logic          trig_ready;
  logic          eoi_valid = 1'b0;
  logic [SW-1:0] eoi_src = '0;
  logic          eoi_ready;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_field = '0;
  logic [SW-1:0] cfg_src = '0;
  logic [RW-1:0] cfg_wdata = '0;
  logic [SW-1:0] rd_src = '0;
  logic [1:0]    rd_pq;
  logic          rd_lsi;
  logic [RW-1:0] rd_route;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [SW-1:0] out_src;
  logic [CW-1:0] out_cpu;
  logic [PW-1:0] out_prio;
  logic [DW-1:0] out_data;
  logic          out_lsi;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  isr_router #(.SPACE_W(SW), .NUM_SRC(NS), .CPU_W(CW), .PRIO_W(PW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_src(trig_src), .trig_ready(trig_ready),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .eoi_ready(eoi_ready),
    .cfg_we(cfg_we), .cfg_field(cfg_field), .cfg_src(cfg_src), .cfg_wdata(cfg_wdata),
    .rd_src(rd_src), .rd_pq(rd_pq), .rd_lsi(rd_lsi), .rd_route(rd_route),
    .out_valid(out_valid), .out_ready(out_ready), .out_src(out_src),
    .out_cpu(out_cpu), .out_prio(out_prio), .out_data(out_data), .out_lsi(out_lsi)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // each task starts just after a falling edge and ends at the next one
  task automatic cfg_write(input logic [1:0] f, input int s, input int d);
    cfg_we = 1'b1; cfg_field = f; cfg_src = SW'(s); cfg_wdata = RW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic strobe(input int kind, input int s);
    if (kind == 0) begin trig_valid = 1'b1; trig_src = SW'(s); end
    else begin eoi_valid = 1'b1; eoi_src = SW'(s); end
    @(negedge clk);
    trig_valid = 1'b0; eoi_valid = 1'b0;
    #1;
  endtask

  // model: returns {raw_forward, next_state} from the state rules
  function automatic logic [2:0] model(input int kind, input logic [1:0] pq);
    logic off;
    off = (pq == 2'b01);
    if (kind == 0) begin
      if (off) return {1'b0, 2'b01};
      if (pq[1] == 1'b0) return {1'b1, 2'b10};
      return {1'b0, 2'b11};
    end
    if (off || pq == 2'b00) return {1'b0, pq};
    if (pq == 2'b10) return {1'b0, 2'b00};
    return {1'b1, 2'b10};
  endfunction

  function automatic string tag_for(input int kind, input logic [1:0] pq, input int m, input logic f);
    if (m != 0 && f) return "R8";
    if (kind == 0) return (pq == 2'b00) ? "R2" : (pq == 2'b01) ? "R4" : "R3";
    return (pq == 2'b11) ? "R6" : (pq == 2'b01) ? "R7" : "R5";
  endfunction

  function automatic int route_word(input int m, input int cpu, input int pr, input int d);
    return (m << (RW - 1)) | ((cpu % (1 << CW)) << (DW + PW)) | ((pr % (1 << PW)) << DW) | (d % (1 << DW));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset contents
    check("R1", "out_valid after reset", out_valid, 0);
    for (int s = 0; s < NS; s++) begin
      rd_src = SW'(s); #1;
      check("R1", "reset state", rd_pq, 2'b01);
      check("R1", "reset mask", rd_route[RW-1], 1);
      check("R1", "reset type", rd_lsi, 0);
    end
    @(negedge clk);

    // sweep: every source, state, mask, strobe kind
    for (int s = 0; s < NS; s++)
      for (int st = 0; st < 4; st++)
        for (int m = 0; m < 2; m++)
          for (int k = 0; k < 2; k++) begin
            int cpu, pr, d;
            logic [2:0] e;
            string t;
            cpu = s * 3 + st;
            pr  = s + st + m;
            d   = s * 17 + st * 5 + k;
            cfg_write(2'd2, s, route_word(m, cpu, pr, d));
            cfg_write(2'd1, s, s & 1);
            cfg_write(2'd0, s, st);
            rd_src = SW'(s); #1;
            check("R9", "written route", rd_route, route_word(m, cpu, pr, d));
            check("R9", "written type", rd_lsi, s & 1);
            strobe(k, s);
            e = model(k, 2'(st));
            t = tag_for(k, 2'(st), m, e[2]);
            check(t, "next state", rd_pq, e[1:0]);
            check(t, "forwarded", out_valid, (e[2] && m == 0) ? 1 : 0);
            if (e[2] && m == 0) begin
              check(t, "out_src", out_src, s);
              check(t, "out_cpu", out_cpu, cpu % (1 << CW));
              check(t, "out_prio", out_prio, pr % (1 << PW));
              check(t, "out_data", out_data, d % (1 << DW));
              check("R12", "out_lsi", out_lsi, s & 1);
            end
            @(negedge clk);
          end

    // R10 numbers beyond the stored range
    cfg_write(2'd2, 0, route_word(0, 1, 1, 8'h5A));
    cfg_write(2'd0, 0, 0);
    cfg_write(2'd2, 15, route_word(0, 2, 2, 8'hA5));
    cfg_write(2'd0, 15, 0);
    strobe(0, 16);
    rd_src = 0; #1;
    check("R10", "trigger 16 output", out_valid, 0);
    check("R10", "trigger 16 source 0 state", rd_pq, 0);
    @(negedge clk);
    strobe(0, 13'h1FFF);
    rd_src = 15; #1;
    check("R10", "trigger top output", out_valid, 0);
    check("R10", "trigger top source 15 state", rd_pq, 0);
    @(negedge clk);
    strobe(1, 16);
    check("R10", "eoi 16 output", out_valid, 0);
    cfg_write(2'd0, 16, 1);
    rd_src = 0; #1;
    check("R10", "cfg 16 source 0 state", rd_pq, 0);
    rd_src = 16; #1;
    check("R10", "readback 16 state", rd_pq, 2'b01);
    check("R10", "readback 16 mask", rd_route[RW-1], 1);
    @(negedge clk);

    // R11 backpressure
    cfg_write(2'd2, 1, route_word(0, 3, 4, 8'h11));
    cfg_write(2'd0, 1, 0);
    cfg_write(2'd2, 2, route_word(0, 5, 6, 8'h22));
    cfg_write(2'd0, 2, 0);
    out_ready = 1'b0;
    strobe(0, 1);
    check("R11", "first event valid", out_valid, 1);
    trig_valid = 1'b1; trig_src = 2; #1;
    check("R11", "trig_ready while held", trig_ready, 0);
    check("R11", "eoi_ready while held", eoi_ready, 0);
    repeat (3) @(negedge clk);
    #1;
    rd_src = 2; #1;
    check("R11", "held out_src", out_src, 1);
    check("R11", "held out_data", out_data, 8'h11);
    check("R11", "held out_valid", out_valid, 1);
    check("R11", "blocked source state", rd_pq, 0);
    out_ready = 1'b1;
    @(negedge clk);
    trig_valid = 1'b0; #1;
    check("R11", "next out_src", out_src, 2);
    check("R11", "next out_valid", out_valid, 1);
    check("R11", "accepted source state", rd_pq, 2'b10);
    @(negedge clk);

    // R9 acceptance order
    cfg_write(2'd2, 3, route_word(0, 0, 0, 8'h33));
    cfg_write(2'd0, 3, 2);
    cfg_write(2'd2, 4, route_word(0, 0, 0, 8'h44));
    cfg_write(2'd0, 4, 0);
    eoi_valid = 1'b1; eoi_src = 3; trig_valid = 1'b1; trig_src = 4; #1;
    check("R9", "trig_ready under eoi", trig_ready, 0);
    check("R9", "eoi_ready", eoi_ready, 1);
    cfg_we = 1'b1; cfg_field = 2'd3; cfg_src = 5; #1;
    check("R9", "eoi_ready under cfg", eoi_ready, 0);
    check("R9", "trig_ready under cfg", trig_ready, 0);
    cfg_we = 1'b0;
    @(negedge clk);
    eoi_valid = 1'b0; trig_valid = 1'b0;
    rd_src = 3; #1;
    check("R5", "eoi winner state", rd_pq, 0);
    rd_src = 4; #1;
    check("R9", "blocked trigger state", rd_pq, 0);
    check("R9", "no output from eoi", out_valid, 0);
    @(negedge clk);

    // R6 full sequence: trigger, trigger, eoi replays, eoi releases
    strobe(0, 4);
    check("R2", "seq first", out_valid, 1);
    @(negedge clk);
    strobe(0, 4);
    rd_src = 4; #1;
    check("R3", "seq queued", rd_pq, 2'b11);
    strobe(1, 4);
    check("R6", "seq replay", out_valid, 1);
    check("R6", "seq replay data", out_data, 8'h44);
    @(negedge clk);
    strobe(1, 4);
    check("R5", "seq release state", rd_pq, 0);
    check("R5", "seq release silent", out_valid, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule